// File: doc/BRIEF.md
# Greedy Neighborhood Local Search

This block improves a set of candidate symbol vectors for a real-valued linear channel `y = H x + w` by greedy descent. Every component of a candidate takes one of four amplitude levels. Starting from each loaded vector in turn, the block looks at every point that differs from the current point in exactly one component. It moves to the cheapest such neighbour when that neighbour lowers the squared residual `||y - H x||^2`. It makes a fixed number of these passes for each start point. After the last start it reports the cheapest vector found over all starts, together with the exact cost of that vector.

Software or an upstream engine writes the received vector, the channel matrix and the start list through a small load port while the block is idle. It then pulses `start`, waits for the one-cycle `done` pulse and reads the result, which stays on the outputs until the next run finishes. The cost of a candidate is built one channel row per cycle with a multiply-accumulate. A candidate therefore costs M cycles, and a run takes roughly `NS * (1 + (M+1) * (1 + PASSES*3*N))` cycles.

Top module: `greedy_local_search`

## Requirements
- R1: A symbol component is a 2-bit level code: 0 means -3, 1 means -1, 2 means +1 and 3 means +3. A load with `ld_kind`=0 writes y[`ld_row`]. A load with `ld_kind`=1 writes H[`ld_row`][`ld_col`]. A load with `ld_kind`=2 writes start vector `ld_row`, with component j in `ld_data[2j+1:2j]`. y and H entries are DW-bit two's complement.
- R2: `cost_out` equals `||y - H x||^2` of the reported `x_out`, exactly, for any DW-bit signed y and H. The accumulation never wraps.
- R3: Each move changes exactly one component of the current point. One pass examines all 3N single-component alternatives.
- R4: The current point moves only when a neighbour's cost is strictly below its cost, so the current cost never rises. When no neighbour improves, the point stays put.
- R5: Among neighbours of equal lowest cost, the one with the lowest component index wins. Within that component, the lowest level code wins.
- R6: Exactly PASSES passes run from each start point, even when more passes would still improve the point.
- R7: The result is the cheapest final point over all NS starts. When costs are equal, the earlier start is kept.
- R8: A `start` pulse while idle raises `busy` from the next cycle until the run ends. `done` is high for exactly one cycle, and `x_out` and `cost_out` then hold until the next run completes.
- R9: Loads presented while `busy` is high are ignored, both by the running search and by later runs.
- R10: After reset `busy`, `done`, `x_out` and `cost_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Load strobe, accepted only while idle |
| ld_kind | input | 2 | Load target: 0 y, 1 H, 2 start vector |
| ld_row | input | IW (2) | Row of y or H, or start-vector index |
| ld_col | input | IW (2) | Column of H |
| ld_data | input | LDW (8) | Signed entry, or packed level codes |
| start | input | 1 | Begin a search run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 2N (8) | Detected vector as level codes |
| cost_out | output | AW (29) | Squared residual of `x_out` |

## Verification
On every cycle the embedded properties check the following. The per-candidate accumulator only grows while a candidate is summed. The current point changes at most one component per update. Its cost never rises during a start. The best cost never rises during a run. `done` is a single-cycle pulse, `busy` follows an accepted `start`, and the stored operands stay frozen when a load arrives during a run. Only the bench scenarios can show the following: which neighbour wins a tie, that the pass limit stops the descent early, which start is kept when costs are equal, the exact cost at full input range, and that the reported vector and cost match a search computed independently from the requirements.

// File: rtl/gls_pkg.sv
`timescale 1ns/1ps
package gls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_EVAL,
    ST_UPDATE,
    ST_DONE
  } gls_state_e;

  localparam logic [1:0] KIND_Y     = 2'd0;
  localparam logic [1:0] KIND_H     = 2'd1;
  localparam logic [1:0] KIND_START = 2'd2;

  // level code to signed amplitude: 0:-3 1:-1 2:+1 3:+3
  function automatic logic signed [2:0] lvl_of(input logic [1:0] code);
    logic signed [2:0] v;
    case (code)
      2'd0:    v = -3'sd3;
      2'd1:    v = -3'sd1;
      2'd2:    v = 3'sd1;
      default: v = 3'sd3;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/gls_store.sv
`timescale 1ns/1ps
module gls_store
  import gls_pkg::*;
#(
  parameter int N   = 4,
  parameter int M   = 4,
  parameter int NS  = 4,
  parameter int DW  = 8,
  parameter int IW  = 2,
  parameter int LDW = 8,
  localparam int XW = 2 * N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy_i,
  input  logic                ld_en_i,
  input  logic [1:0]          ld_kind_i,
  input  logic [IW-1:0]       ld_row_i,
  input  logic [IW-1:0]       ld_col_i,
  input  logic [LDW-1:0]      ld_data_i,
  output logic [M*DW-1:0]     y_o,
  output logic [M*N*DW-1:0]   h_o,
  output logic [NS*XW-1:0]    st_o
);

  logic [M*DW-1:0]   y_q,  y_d;
  logic [M*N*DW-1:0] h_q,  h_d;
  logic [NS*XW-1:0]  st_q, st_d;
  logic              wr_en;

  assign wr_en = ld_en_i && !busy_i;

  always_comb begin
    int ri;
    int ci;
    ri   = int'(ld_row_i);
    ci   = int'(ld_col_i);
    y_d  = y_q;
    h_d  = h_q;
    st_d = st_q;
    case (ld_kind_i)
      KIND_Y:     if (ri < M) y_d[ri*DW +: DW] = ld_data_i[DW-1:0];
      KIND_H:     if (ri < M && ci < N) h_d[(ri*N+ci)*DW +: DW] = ld_data_i[DW-1:0];
      KIND_START: if (ri < NS) st_d[ri*XW +: XW] = ld_data_i[XW-1:0];
      default:    ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q  <= '0;
      h_q  <= '0;
      st_q <= '0;
    end else if (wr_en) begin
      y_q  <= y_d;
      h_q  <= h_d;
      st_q <= st_d;
    end
  end

  assign y_o  = y_q;
  assign h_o  = h_q;
  assign st_o = st_q;

  // R9: operands frozen while a run is in progress
  p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && ld_en_i) |=> ($stable(y_q) && $stable(h_q) && $stable(st_q)));

endmodule

// File: rtl/gls_cost.sv
`timescale 1ns/1ps
module gls_cost
  import gls_pkg::*;
#(
  parameter int N   = 4,
  parameter int M   = 4,
  parameter int DW  = 8,
  parameter int RIW = 2,
  parameter int AW  = 29,
  localparam int XW = 2 * N,
  localparam int PW = DW + 2,
  localparam int SW = PW + $clog2(N) + 1,
  localparam int QW = 2 * SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              first_i,
  input  logic [RIW-1:0]    row_i,
  input  logic [M*DW-1:0]   y_i,
  input  logic [M*N*DW-1:0] h_i,
  input  logic [XW-1:0]     cand_i,
  output logic [AW-1:0]     acc_o
);

  logic signed [SW-1:0] dot;
  logic signed [SW-1:0] res;
  logic signed [QW-1:0] sq;
  logic [AW-1:0]        acc_q, acc_d;

  // residual of one channel row, squared
  always_comb begin
    int ri;
    ri  = int'(row_i);
    dot = '0;
    for (int j = 0; j < N; j++) begin
      dot = dot + SW'(PW'($signed(h_i[(ri*N+j)*DW +: DW])) * PW'(lvl_of(cand_i[2*j +: 2])));
    end
    res   = SW'($signed(y_i[ri*DW +: DW])) - dot;
    sq    = QW'(res) * QW'(res);
    acc_d = (first_i ? '0 : acc_q) + AW'($unsigned(sq));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en_i) acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R2: partial sums of one candidate never wrap downward
  p_acc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !first_i) |=> (acc_q >= $past(acc_q)));

endmodule

// File: rtl/gls_ctrl.sv
`timescale 1ns/1ps
module gls_ctrl
  import gls_pkg::*;
#(
  parameter int N      = 4,
  parameter int M      = 4,
  parameter int NS     = 4,
  parameter int PASSES = 2,
  parameter int RIW    = 2,
  parameter int AW     = 29,
  localparam int XW  = 2 * N,
  localparam int SIW = (NS > 1) ? $clog2(NS) : 1,
  localparam int JIW = (N > 1) ? $clog2(N) : 1,
  localparam int PIW = $clog2(PASSES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     acc_i,
  input  logic [NS*XW-1:0]  st_i,
  output logic [XW-1:0]     cand_o,
  output logic [RIW-1:0]    row_o,
  output logic              en_o,
  output logic              first_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [XW-1:0]     x_o,
  output logic [AW-1:0]     cost_o
);

  gls_state_e      state_q, state_d;
  logic [SIW-1:0]  s_q, s_d;
  logic [PIW-1:0]  pass_q, pass_d;
  logic            k0_q, k0_d;
  logic [JIW-1:0]  j_q, j_d;
  logic [1:0]      t_q, t_d;
  logic [RIW-1:0]  r_q, r_d;
  logic [XW-1:0]   cur_q, cur_d, bn_q, bn_d, best_q, best_d, res_x_q, res_x_d;
  logic [AW-1:0]   cur_cost_q, cur_cost_d, bn_cost_q, bn_cost_d;
  logic [AW-1:0]   best_cost_q, best_cost_d, res_cost_q, res_cost_d;
  logic            cur_ok_q, cur_ok_d, best_ok_q, best_ok_d;

  logic [XW-1:0]   cand, nb_x, fin_x;
  logic [AW-1:0]   nb_c, fin_c;
  logic [1:0]      cur_sel, alt;
  logic            better, last_nb, last_pass, take_best;

  // candidate: current point, or current point with one component replaced
  always_comb begin
    cur_sel = cur_q[int'(j_q)*2 +: 2];
    alt     = t_q + {1'b0, (t_q >= cur_sel)};
    cand    = cur_q;
    if (!k0_q) begin
      for (int j = 0; j < N; j++) begin
        if (JIW'(j) == j_q) cand[2*j +: 2] = alt;
      end
    end
  end

  always_comb begin
    better    = acc_i < bn_cost_q;
    nb_x      = better ? cand : bn_q;
    nb_c      = better ? acc_i : bn_cost_q;
    last_nb   = (j_q == JIW'(N-1)) && (t_q == 2'd2);
    last_pass = (pass_q == PIW'(PASSES-1));
    take_best = !best_ok_q || (nb_c < best_cost_q);
    fin_x     = take_best ? nb_x : best_q;
    fin_c     = take_best ? nb_c : best_cost_q;
  end

  // next-state process
  always_comb begin
    state_d = state_q;  s_d = s_q;  pass_d = pass_q;  k0_d = k0_q;
    j_d = j_q;  t_d = t_q;  r_d = r_q;
    cur_d = cur_q;  cur_cost_d = cur_cost_q;  cur_ok_d = cur_ok_q;
    bn_d = bn_q;  bn_cost_d = bn_cost_q;
    best_d = best_q;  best_cost_d = best_cost_q;  best_ok_d = best_ok_q;
    res_x_d = res_x_q;  res_cost_d = res_cost_q;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d   = ST_LOAD;
          s_d       = '0;
          best_ok_d = 1'b0;
        end
      end
      ST_LOAD: begin
        cur_d    = st_i[int'(s_q)*XW +: XW];
        cur_ok_d = 1'b0;
        k0_d     = 1'b1;
        pass_d   = '0;
        r_d      = '0;
        state_d  = ST_EVAL;
      end
      ST_EVAL: begin
        if (r_q == RIW'(M-1)) begin
          r_d     = '0;
          state_d = ST_UPDATE;
        end else begin
          r_d = r_q + 1'b1;
        end
      end
      ST_UPDATE: begin
        state_d = ST_EVAL;
        if (k0_q) begin
          cur_cost_d = acc_i;
          cur_ok_d   = 1'b1;
          bn_d       = cur_q;
          bn_cost_d  = acc_i;
          k0_d       = 1'b0;
          j_d        = '0;
          t_d        = '0;
        end else begin
          bn_d      = nb_x;
          bn_cost_d = nb_c;
          if (!last_nb) begin
            if (t_q == 2'd2) begin
              t_d = '0;
              j_d = j_q + 1'b1;
            end else begin
              t_d = t_q + 1'b1;
            end
          end else begin
            cur_d      = nb_x;
            cur_cost_d = nb_c;
            t_d        = '0;
            j_d        = '0;
            if (!last_pass) begin
              pass_d = pass_q + 1'b1;
            end else begin
              best_d      = fin_x;
              best_cost_d = fin_c;
              best_ok_d   = 1'b1;
              if (s_q == SIW'(NS-1)) begin
                state_d    = ST_DONE;
                res_x_d    = fin_x;
                res_cost_d = fin_c;
              end else begin
                s_d     = s_q + 1'b1;
                state_d = ST_LOAD;
              end
            end
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  s_q <= '0;  pass_q <= '0;  k0_q <= 1'b0;
      j_q <= '0;  t_q <= '0;  r_q <= '0;
      cur_q <= '0;  cur_cost_q <= '0;  cur_ok_q <= 1'b0;
      bn_q <= '0;  bn_cost_q <= '0;
      best_q <= '0;  best_cost_q <= '0;  best_ok_q <= 1'b0;
      res_x_q <= '0;  res_cost_q <= '0;
    end else begin
      state_q <= state_d;  s_q <= s_d;  pass_q <= pass_d;  k0_q <= k0_d;
      j_q <= j_d;  t_q <= t_d;  r_q <= r_d;
      cur_q <= cur_d;  cur_cost_q <= cur_cost_d;  cur_ok_q <= cur_ok_d;
      bn_q <= bn_d;  bn_cost_q <= bn_cost_d;
      best_q <= best_d;  best_cost_q <= best_cost_d;  best_ok_q <= best_ok_d;
      res_x_q <= res_x_d;  res_cost_q <= res_cost_d;
    end
  end

  assign cand_o  = cand;
  assign row_o   = r_q;
  assign en_o    = (state_q == ST_EVAL);
  assign first_o = (r_q == '0);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = (state_q == ST_DONE);
  assign x_o     = res_x_q;
  assign cost_o  = res_cost_q;

  function automatic int coords_changed(input logic [XW-1:0] a, input logic [XW-1:0] b);
    int n;
    n = 0;
    for (int j = 0; j < N; j++) if (a[2*j +: 2] != b[2*j +: 2]) n++;
    return n;
  endfunction

  // R3: a move touches at most one component
  p_one_coord_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ok_q && $past(cur_ok_q)) |-> (coords_changed(cur_q, $past(cur_q)) <= 1));

  // R4: current cost never rises within a start
  p_cost_nonincr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ok_q && $past(cur_ok_q)) |-> (cur_cost_q <= $past(cur_cost_q)));

  // R7: best cost over starts never rises within a run
  p_best_nonincr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (best_ok_q && $past(best_ok_q)) |-> (best_cost_q <= $past(best_cost_q)));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8: an accepted start makes the block busy
  p_busy_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> busy_o);

endmodule

// File: rtl/greedy_local_search.sv
`timescale 1ns/1ps
module greedy_local_search #(
  parameter int N      = 4,
  parameter int M      = 4,
  parameter int NS     = 4,
  parameter int PASSES = 2,
  parameter int DW     = 8,
  localparam int XW  = 2 * N,
  localparam int LDW = (DW > XW) ? DW : XW,
  localparam int MX  = (M > N) ? ((M > NS) ? M : NS) : ((N > NS) ? N : NS),
  localparam int IW  = (MX > 1) ? $clog2(MX) : 1,
  localparam int RIW = (M > 1) ? $clog2(M) : 1,
  localparam int SW  = DW + 2 + $clog2(N) + 1,
  localparam int AW  = 2 * SW + $clog2(M) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [1:0]      ld_kind,
  input  logic [IW-1:0]   ld_row,
  input  logic [IW-1:0]   ld_col,
  input  logic [LDW-1:0]  ld_data,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [XW-1:0]   x_out,
  output logic [AW-1:0]   cost_out
);

  logic [M*DW-1:0]   y_w;
  logic [M*N*DW-1:0] h_w;
  logic [NS*XW-1:0]  st_w;
  logic [XW-1:0]     cand_w;
  logic [RIW-1:0]    row_w;
  logic              en_w, first_w;
  logic [AW-1:0]     acc_w;

  gls_store #(.N(N), .M(M), .NS(NS), .DW(DW), .IW(IW), .LDW(LDW)) u_store (
    .clk(clk), .rst_n(rst_n), .busy_i(busy), .ld_en_i(ld_en), .ld_kind_i(ld_kind),
    .ld_row_i(ld_row), .ld_col_i(ld_col), .ld_data_i(ld_data),
    .y_o(y_w), .h_o(h_w), .st_o(st_w)
  );

  gls_cost #(.N(N), .M(M), .DW(DW), .RIW(RIW), .AW(AW)) u_cost (
    .clk(clk), .rst_n(rst_n), .en_i(en_w), .first_i(first_w), .row_i(row_w),
    .y_i(y_w), .h_i(h_w), .cand_i(cand_w), .acc_o(acc_w)
  );

  gls_ctrl #(.N(N), .M(M), .NS(NS), .PASSES(PASSES), .RIW(RIW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .acc_i(acc_w), .st_i(st_w),
    .cand_o(cand_w), .row_o(row_w), .en_o(en_w), .first_o(first_w),
    .busy_o(busy), .done_o(done), .x_o(x_out), .cost_o(cost_out)
  );

endmodule

// File: tb/sim_greedy_local_search.sv
`timescale 1ns/1ps
module sim_greedy_local_search;

  localparam int N = 4, M = 4, NS = 4, PASSES = 2, DW = 8;
  localparam int XW  = 2 * N;
  localparam int LDW = 8;
  localparam int IW  = 2;
  localparam int AW  = 2 * (DW + 2 + $clog2(N) + 1) + $clog2(M) + 1;

  logic clk, rst_n, ld_en, start, busy, done;
  logic [1:0] ld_kind;
  logic [IW-1:0] ld_row, ld_col;
  logic [LDW-1:0] ld_data;
  logic [XW-1:0] x_out;
  logic [AW-1:0] cost_out;

  greedy_local_search u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_kind(ld_kind), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .start(start), .busy(busy), .done(done),
    .x_out(x_out), .cost_out(cost_out)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, seed = 7;
  int hm[M][N];
  int yv[M];
  int sv[NS][N];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 16) & 32767;
  endfunction

  function automatic longint mcost(input int xc[N]);
    longint c = 0;
    for (int r = 0; r < M; r++) begin
      longint e = yv[r];
      for (int j = 0; j < N; j++) e -= hm[r][j] * (2 * xc[j] - 3);
      c += e * e;
    end
    return c;
  endfunction

  function automatic logic [XW-1:0] pack(input int xc[N]);
    logic [XW-1:0] v;
    for (int j = 0; j < N; j++) v[2*j +: 2] = 2'(xc[j]);
    return v;
  endfunction

  // independent search following R3..R7
  task automatic model(output logic [XW-1:0] bx, output longint bc);
    int cur[N], nb[N], tmp[N];
    longint cc, nc, c;
    bx = '0; bc = 0;
    for (int s = 0; s < NS; s++) begin
      cur = sv[s];
      cc = mcost(cur);
      for (int p = 0; p < PASSES; p++) begin
        nb = cur; nc = cc;
        for (int j = 0; j < N; j++)
          for (int code = 0; code < 4; code++)
            if (code != cur[j]) begin
              tmp = cur; tmp[j] = code; c = mcost(tmp);
              if (c < nc) begin nb = tmp; nc = c; end
            end
        cur = nb; cc = nc;
      end
      if (s == 0 || cc < bc) begin bx = pack(cur); bc = cc; end
    end
  endtask

  task automatic ld(input logic [1:0] kind, input int row, input int col, input logic [LDW-1:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_kind = kind; ld_row = IW'(row); ld_col = IW'(col); ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_all();
    for (int r = 0; r < M; r++) ld(2'd0, r, 0, hm[r][0] == 0 ? LDW'(yv[r]) : LDW'(yv[r]));
    for (int r = 0; r < M; r++)
      for (int c = 0; c < N; c++) ld(2'd1, r, c, LDW'(hm[r][c]));
    for (int s = 0; s < NS; s++) ld(2'd2, s, 0, pack(sv[s]));
  endtask

  // start, wait for done, check handshake (R8)
  task automatic run(output logic [XW-1:0] rx, output longint rc);
    int cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
    while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
    check(done == 1'b1, "R8", "done seen", longint'(done), 1);
    rx = x_out; rc = longint'(cost_out);
    @(negedge clk);
    check(done == 1'b0 && x_out == rx && longint'(cost_out) == rc, "R8", "done pulse and hold",
          longint'(done), 0);
  endtask

  task automatic run_vs_model(input string req);
    logic [XW-1:0] ex, gx; longint ec, gc;
    load_all();
    model(ex, ec);
    run(gx, gc);
    check(gx == ex, req, "x_out vs model", longint'(gx), longint'(ex));
    check(gc == ec, req, "cost_out vs model", gc, ec);
  endtask

  task automatic set_diag(input int g);
    for (int r = 0; r < M; r++) for (int c = 0; c < N; c++) hm[r][c] = (r == c) ? g : 0;
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0, "R10", "busy/done after reset", longint'({busy, done}), 0);
    check(x_out == 0 && cost_out == 0, "R10", "outputs after reset", longint'(cost_out), 0);
  endtask

  // R5 R6: equal-gain neighbours, pass limit stops with two coords fixed
  task automatic t_tie();
    logic [XW-1:0] gx; longint gc;
    set_diag(1);
    for (int r = 0; r < M; r++) yv[r] = 0;
    for (int s = 0; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = 0;
    load_all(); run(gx, gc);
    check(gx == 8'h05, "R5", "tie order x_out", longint'(gx), 5);
    check(gc == 20, "R6", "two passes only, cost", gc, 20);
  endtask

  // R4 R7: flat cost, nothing moves, first start kept
  task automatic t_flat();
    logic [XW-1:0] gx; longint gc;
    set_diag(0);
    yv = '{5, 0, 0, 0};
    for (int s = 0; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = (s + j) % 4;
    load_all(); run(gx, gc);
    check(gx == pack(sv[0]), "R4", "no move on equal cost", longint'(gx), longint'(pack(sv[0])));
    check(gc == 25, "R7", "equal cost keeps start 0", gc, 25);
  endtask

  // R1 R3: one component off reaches the exact solution
  task automatic t_one_off();
    logic [XW-1:0] gx; longint gc;
    int xt[N] = '{3, 0, 2, 1};
    set_diag(4);
    for (int r = 0; r < M; r++) yv[r] = 4 * (2 * xt[r] - 3);
    sv[0] = xt; sv[0][2] = 0;
    for (int s = 1; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = 3;
    load_all(); run(gx, gc);
    check(gx == pack(xt), "R3", "single change reaches solution", longint'(gx), longint'(pack(xt)));
    check(gc == 0, "R1", "level encoding gives zero residual", gc, 0);
  endtask

  // R7: only the last start holds the answer
  task automatic t_late_best();
    logic [XW-1:0] gx; longint gc;
    int xt[N] = '{3, 0, 2, 1};
    set_diag(4);
    for (int r = 0; r < M; r++) yv[r] = 4 * (2 * xt[r] - 3);
    for (int s = 0; s < NS - 1; s++) for (int j = 0; j < N; j++) sv[s][j] = 0;
    sv[NS-1] = xt;
    load_all(); run(gx, gc);
    check(gx == pack(xt), "R7", "later better start wins", longint'(gx), longint'(pack(xt)));
    check(gc == 0, "R7", "later start cost", gc, 0);
  endtask

  // R2: extreme magnitudes
  task automatic t_range();
    for (int r = 0; r < M; r++) begin
      yv[r] = 127;
      for (int c = 0; c < N; c++) hm[r][c] = -128;
    end
    for (int s = 0; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = 3;
    run_vs_model("R2");
  endtask

  // R9: loads during a run change neither this run nor the next
  task automatic t_busy_load();
    logic [XW-1:0] ex, gx; longint ec, gc; int cnt = 0;
    set_diag(3);
    yv = '{-9, 3, 9, -3};
    for (int s = 0; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = (s * 3 + j) % 4;
    load_all();
    model(ex, ec);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int r = 0; r < M; r++) ld(2'd0, r, 0, 8'h7f);
    ld(2'd1, 0, 0, 8'h00);
    ld(2'd2, 0, 0, 8'hff);
    while (!done && cnt < 20000) begin @(negedge clk); cnt++; end
    check(x_out == ex && longint'(cost_out) == ec, "R9", "run ignores busy loads",
          longint'(cost_out), ec);
    run(gx, gc);
    check(gx == ex && gc == ec, "R9", "stored data untouched", gc, ec);
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      for (int r = 0; r < M; r++) begin
        yv[r] = (rnd() % 256) - 128;
        for (int c = 0; c < N; c++) hm[r][c] = (k < 3) ? (rnd() % 256) - 128 : (rnd() % 15) - 7;
      end
      for (int s = 0; s < NS; s++) for (int j = 0; j < N; j++) sv[s][j] = rnd() % 4;
      run_vs_model("R4");
    end
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; start = 1'b0; ld_kind = '0;
    ld_row = '0; ld_col = '0; ld_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tie();
    t_flat();
    t_one_off();
    t_late_best();
    t_range();
    t_busy_load();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule